// File: doc/BRIEF.md
# Upset-Guarded One-Hot Sequencer

This block is a five-state controller for a fetch, evaluate and forward flow. Its state register holds a one-hot pattern. Every cycle a combinational legality check looks at that register. A legal pattern lets the normal next-state logic drive the register. An illegal pattern is what a single flipped storage bit leaves behind. It makes a next-state multiplexer load the idle state at the next clock edge, and it raises a registered one-cycle upset flag. Recovery does not depend on a default branch of a case statement. The selection sits in explicit logic that synthesis keeps.

The legality check is chosen by a parameter. Parity mode accepts any pattern with an odd number of set bits, which is the cheapest check that catches every single-bit flip. Strict mode accepts exactly one set bit. The control outputs are registered. They decode the value being loaded into the state register and are gated by a strict one-hot test, so a corrupted pattern never turns on two controls at once. A test-only injection port XORs a mask into the state register for one cycle, which lets a bench emulate an upset in any bit of any state. All inputs are taken to be synchronous to the clock.

Top module: `onehot_guard_fsm`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state register loads 5'b00001 (idle) and the upset flag and all control outputs go low, whatever the other inputs do.
- R2: State bits are bit 0 idle, bit 1 fetch, bit 2 evaluate, bit 3 reject, bit 4 forward. Idle moves to fetch when `i_start` is high. Fetch moves to evaluate when `i_data_valid` is high. Reject returns to idle after one cycle. Forward returns to idle when `i_done` is high. Every other case holds the current state.
- R3: Evaluate always lasts one cycle. It moves to forward when `i_check_ok` is high and to reject when it is low.
- R4: When the state register holds an even-parity pattern (for example, any single-bit flip of a legal state) and no injection is requested, the next edge loads idle (5'b00001).
- R5: `o_upset` is high for exactly the one cycle after an edge at which a recovery was forced, and low in every other cycle.
- R6: At an edge where `i_inj_en` is high, the state register loads its current value XOR `i_inj_mask`. No transition takes place and no upset is flagged at that edge.
- R7: When the state register holds any pattern that does not have exactly one set bit, all four control outputs are low.
- R8: The control outputs `o_fetch`, `o_work`, `o_reject` and `o_send` are registered. Each is high exactly when the state register holds fetch, evaluate, reject or forward respectively.
- R9: With `CHECK_MODE` strict, an odd-weight pattern with more than one set bit (such as 5'b00111) is also recovered and flagged. With parity mode it is not flagged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i_start | input | 1 | Begin a transaction from idle |
| i_data_valid | input | 1 | Fetched data is available |
| i_check_ok | input | 1 | Evaluation verdict, high means accept |
| i_done | input | 1 | Forwarding is complete |
| i_inj_en | input | 1 | Test only: apply the injection mask this edge |
| i_inj_mask | input | 5 | Test only: bits to flip in the state register |
| o_state | output | 5 | Current state register contents |
| o_fetch | output | 1 | Registered: fetch state active |
| o_work | output | 1 | Registered: evaluate state active |
| o_reject | output | 1 | Registered: reject state active |
| o_send | output | 1 | Registered: forward state active |
| o_upset | output | 1 | Registered one-cycle pulse on forced recovery |

## Verification
The bench builds two copies side by side, one with the default parity check and one with `CHECK_MODE` set to strict, and drives them with the same stimulus. Single-bit flips must behave the same in both. Every one of the five bits is flipped in each of the five states, and the random run keeps mixing upsets into normal traffic. The strict copy also brings the odd-weight, multi-bit pattern into reach. Only that pattern separates the two checks: strict mode must recover from it at once, and parity mode must not flag it at the next edge.

// File: rtl/ohg_pkg.sv
// Package: shared encodings for the upset-guarded one-hot sequencer.
// Assumes five states, one flip-flop per state.
package ohg_pkg;

    localparam int STATE_W = 5;

    localparam int IDX_IDLE  = 0;
    localparam int IDX_FETCH = 1;
    localparam int IDX_EVAL  = 2;
    localparam int IDX_REJ   = 3;
    localparam int IDX_SEND  = 4;

    localparam logic [STATE_W-1:0] ST_IDLE  = STATE_W'(1) << IDX_IDLE;
    localparam logic [STATE_W-1:0] ST_FETCH = STATE_W'(1) << IDX_FETCH;
    localparam logic [STATE_W-1:0] ST_EVAL  = STATE_W'(1) << IDX_EVAL;
    localparam logic [STATE_W-1:0] ST_REJ   = STATE_W'(1) << IDX_REJ;
    localparam logic [STATE_W-1:0] ST_SEND  = STATE_W'(1) << IDX_SEND;

    // Legality check flavour: odd parity, or exactly one bit set.
    typedef enum logic {
        CHK_PARITY = 1'b0,
        CHK_STRICT = 1'b1
    } chk_mode_e;

endpackage

// File: rtl/ohg_legal_check.sv
// Module: combinational legality test of a one-hot vector.
// PARITY mode passes any odd-weight vector. STRICT mode passes exactly one set bit.
// Holds no storage, so it cannot be upset itself.
module ohg_legal_check
    import ohg_pkg::*;
#(
    parameter int        WIDTH = STATE_W,
    parameter chk_mode_e MODE  = CHK_PARITY
) (
    input  logic [WIDTH-1:0] i_vec,
    output logic             o_legal
);

    localparam int CNT_W = $clog2(WIDTH + 1);

    generate
        if (MODE == CHK_STRICT) begin : g_strict
            logic [CNT_W-1:0] ones;
            // Count the set bits and demand exactly one.
            always_comb begin
                ones = '0;
                for (int i = 0; i < WIDTH; i++) begin
                    ones = ones + CNT_W'(i_vec[i]);
                end
                o_legal = (ones == CNT_W'(1));
            end
        end else begin : g_parity
            // Odd parity: one XOR tree.
            always_comb begin
                o_legal = ^i_vec;
            end
        end
    endgenerate

endmodule

// File: rtl/ohg_next_state.sv
// Module: normal next-state logic of the sequencer, written per state bit.
// Assumes a legal one-hot input. The caller's multiplexer discards the result otherwise.
module ohg_next_state
    import ohg_pkg::*;
(
    input  logic [STATE_W-1:0] i_cur,
    input  logic               i_start,
    input  logic               i_data_valid,
    input  logic               i_check_ok,
    input  logic               i_done,
    output logic [STATE_W-1:0] o_nxt
);

    // Each next-state bit is the OR of the arcs that enter it.
    always_comb begin
        o_nxt[IDX_IDLE]  = (i_cur[IDX_IDLE] & ~i_start)
                         |  i_cur[IDX_REJ]
                         | (i_cur[IDX_SEND] & i_done);
        o_nxt[IDX_FETCH] = (i_cur[IDX_IDLE] & i_start)
                         | (i_cur[IDX_FETCH] & ~i_data_valid);
        o_nxt[IDX_EVAL]  =  i_cur[IDX_FETCH] & i_data_valid;
        o_nxt[IDX_REJ]   =  i_cur[IDX_EVAL] & ~i_check_ok;
        o_nxt[IDX_SEND]  = (i_cur[IDX_EVAL] & i_check_ok)
                         | (i_cur[IDX_SEND] & ~i_done);
    end

endmodule

// File: rtl/ohg_ctrl_out.sv
// Module: registered control outputs, decoded from the value being loaded.
// A strict one-hot gate keeps every control low for a corrupted pattern.
// Synchronous active-low reset.
module ohg_ctrl_out
    import ohg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] i_load,
    output logic               o_fetch,
    output logic               o_work,
    output logic               o_reject,
    output logic               o_send
);

    logic load_onehot;

    ohg_legal_check #(
        .WIDTH (STATE_W),
        .MODE  (CHK_STRICT)
    ) u_gate (
        .i_vec   (i_load),
        .o_legal (load_onehot)
    );

    // Register the gated decode so the outputs line up with the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_fetch  <= 1'b0;
            o_work   <= 1'b0;
            o_reject <= 1'b0;
            o_send   <= 1'b0;
        end else begin
            o_fetch  <= load_onehot & i_load[IDX_FETCH];
            o_work   <= load_onehot & i_load[IDX_EVAL];
            o_reject <= load_onehot & i_load[IDX_REJ];
            o_send   <= load_onehot & i_load[IDX_SEND];
        end
    end

endmodule

// File: rtl/onehot_guard_fsm.sv
// Module: top of the upset-guarded one-hot sequencer.
// The current-state register is checked each cycle. An illegal value makes the
// multiplexer load idle and raises a one-cycle upset pulse.
// Assumes synchronous inputs and at most one flipped bit per cycle.
// The injection port is for test only and takes priority over everything except reset.
module onehot_guard_fsm
    import ohg_pkg::*;
#(
    parameter chk_mode_e CHECK_MODE = CHK_PARITY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               i_start,
    input  logic               i_data_valid,
    input  logic               i_check_ok,
    input  logic               i_done,
    input  logic               i_inj_en,
    input  logic [STATE_W-1:0] i_inj_mask,
    output logic [STATE_W-1:0] o_state,
    output logic               o_fetch,
    output logic               o_work,
    output logic               o_reject,
    output logic               o_send,
    output logic               o_upset
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic [STATE_W-1:0] nxt_normal;
    logic               cur_legal;
    logic               upset_q;

    ohg_legal_check #(
        .WIDTH (STATE_W),
        .MODE  (CHECK_MODE)
    ) u_cur_check (
        .i_vec   (state_q),
        .o_legal (cur_legal)
    );

    ohg_next_state u_next (
        .i_cur        (state_q),
        .i_start      (i_start),
        .i_data_valid (i_data_valid),
        .i_check_ok   (i_check_ok),
        .i_done       (i_done),
        .o_nxt        (nxt_normal)
    );

    // Next-state multiplexer: injection, then normal path, else forced recovery.
    always_comb begin
        if (i_inj_en) begin
            state_d = state_q ^ i_inj_mask;
        end else if (cur_legal) begin
            state_d = nxt_normal;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Upset pulse: set for the cycle after a forced recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upset_q <= 1'b0;
        end else begin
            upset_q <= ~cur_legal & ~i_inj_en;
        end
    end

    ohg_ctrl_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_load   (state_d),
        .o_fetch  (o_fetch),
        .o_work   (o_work),
        .o_reject (o_reject),
        .o_send   (o_send)
    );

    assign o_state = state_q;
    assign o_upset = upset_q;

endmodule

// File: rtl/ohg_checker.sv
// Module: temporal properties of the sequencer, attached to the top by bind.
// Observes ports only.
module ohg_checker
    import ohg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               i_start,
    input logic               i_check_ok,
    input logic               i_inj_en,
    input logic [STATE_W-1:0] i_inj_mask,
    input logic [STATE_W-1:0] o_state,
    input logic               o_fetch,
    input logic               o_work,
    input logic               o_reject,
    input logic               o_send,
    input logic               o_upset
);

    // R1: reset loads idle and clears the flag.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (o_state == ST_IDLE && !o_upset));

    // R2: start leaves idle for fetch.
    a_r2_idle_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (o_state == ST_IDLE && i_start && !i_inj_en) |=> (o_state == ST_FETCH));

    // R3: an accepting verdict in evaluate leads to forward.
    a_r3_eval_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (o_state == ST_EVAL && i_check_ok && !i_inj_en) |=> (o_state == ST_SEND));

    // R4: an even-parity register is replaced by idle and flagged.
    a_r4_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (!(^o_state) && !i_inj_en) |=> (o_state == ST_IDLE && o_upset));

    // R5: the upset flag never lasts two cycles.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        o_upset |=> !o_upset);

    // R6: injection flips exactly the mask bits and raises no flag.
    a_r6_inject: assert property (@(posedge clk) disable iff (!rst_n)
        i_inj_en |=> (o_state == $past(o_state ^ i_inj_mask) && !o_upset));

    // R7: no control is active while the register is not one-hot.
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(o_state) != 1) |-> !(o_fetch | o_work | o_reject | o_send));

    // R8: each registered control agrees with the state register.
    a_r8_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (o_fetch == (o_state == ST_FETCH)) && (o_work == (o_state == ST_EVAL)) &&
        (o_reject == (o_state == ST_REJ)) && (o_send == (o_state == ST_SEND)));

endmodule

bind onehot_guard_fsm ohg_checker i_ohg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_start    (i_start),
    .i_check_ok (i_check_ok),
    .i_inj_en   (i_inj_en),
    .i_inj_mask (i_inj_mask),
    .o_state    (o_state),
    .o_fetch    (o_fetch),
    .o_work     (o_work),
    .o_reject   (o_reject),
    .o_send     (o_send),
    .o_upset    (o_upset)
);

// File: tb/test_onehot_guard_fsm.sv
`timescale 1ns/100ps
// Bench: two copies (parity and strict check) share one stimulus stream and are
// compared against a reference model each cycle.
module test_onehot_guard_fsm;
    import ohg_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       st, dv, ok, dn, inj;
    logic [4:0] mask;

    logic [4:0] sa, sb;
    logic       fa, wa, ra, ca, ua;
    logic       fb, wb, rb, cb, ub;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [4:0] m;

    always #2.5 clk = ~clk;

    onehot_guard_fsm i_onehot_guard_fsm (
        .clk(clk), .rst_n(rst_n), .i_start(st), .i_data_valid(dv),
        .i_check_ok(ok), .i_done(dn), .i_inj_en(inj), .i_inj_mask(mask),
        .o_state(sa), .o_fetch(fa), .o_work(wa), .o_reject(ra), .o_send(ca),
        .o_upset(ua));

    onehot_guard_fsm #(.CHECK_MODE(CHK_STRICT)) i_onehot_guard_fsm_strict (
        .clk(clk), .rst_n(rst_n), .i_start(st), .i_data_valid(dv),
        .i_check_ok(ok), .i_done(dn), .i_inj_en(inj), .i_inj_mask(mask),
        .o_state(sb), .o_fetch(fb), .o_work(wb), .o_reject(rb), .o_send(cb),
        .o_upset(ub));

    function automatic logic [4:0] f_next(input logic [4:0] s,
                                          input logic a, b, c, d);
        case (s)
            5'b00001: return a ? 5'b00010 : 5'b00001;
            5'b00010: return b ? 5'b00100 : 5'b00010;
            5'b00100: return c ? 5'b10000 : 5'b01000;
            5'b01000: return 5'b00001;
            5'b10000: return d ? 5'b00001 : 5'b10000;
            default:  return 5'b00001;
        endcase
    endfunction

    function automatic logic [3:0] f_ctl(input logic [4:0] s);
        return ($countones(s) == 1) ? {s[1], s[2], s[3], s[4]} : 4'b0000;
    endfunction

    task automatic check(input string req, input logic [4:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One clock with given inputs; compares both copies against the model.
    task automatic step(input logic a, b, c, d, e, input logic [4:0] k,
                        input string tag);
        logic [4:0] exp_s;
        logic       exp_e;
        string      stag;
        @(negedge clk);
        st = a; dv = b; ok = c; dn = d; inj = e; mask = k;
        if (e) begin
            exp_s = m ^ k; exp_e = 1'b0; stag = "R6";
        end else if ($countones(m) != 1) begin
            exp_s = 5'b00001; exp_e = 1'b1; stag = "R4";
        end else begin
            exp_s = f_next(m, a, b, c, d); exp_e = 1'b0; stag = tag;
        end
        @(posedge clk); #1;
        m = exp_s;
        check(stag, sa, exp_s);
        check(stag, sb, exp_s);
        check("R5", {4'b0, ua}, {4'b0, exp_e});
        check("R5", {4'b0, ub}, {4'b0, exp_e});
        check(($countones(exp_s) == 1) ? "R8" : "R7", {1'b0, fa, wa, ra, ca}, {1'b0, f_ctl(exp_s)});
        check(($countones(exp_s) == 1) ? "R8" : "R7", {1'b0, fb, wb, rb, cb}, {1'b0, f_ctl(exp_s)});
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; st = 1'b1; dv = 1'b1; ok = 1'b1; dn = 1'b0; inj = 1'b0; mask = '0;
        @(posedge clk); @(posedge clk); #1;
        m = 5'b00001;
        check("R1", sa, 5'b00001);
        check("R1", sb, 5'b00001);
        check("R1", {ua, fa, wa, ra, ca}, 5'b00000);
        check("R1", {ub, fb, wb, rb, cb}, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1; st = 1'b0; dv = 1'b0; ok = 1'b0;
    endtask

    // Drive the machine from idle to the given state index.
    task automatic go_to(input int idx);
        if (idx >= 1) step(1, 0, 0, 0, 0, '0, "R2");
        if (idx >= 2) step(0, 1, 0, 0, 0, '0, "R2");
        if (idx == 3) step(0, 0, 0, 0, 0, '0, "R3");
        if (idx == 4) step(0, 0, 1, 0, 0, '0, "R3");
    endtask

    initial begin
        int unsigned seed_out;
        seed_out = $urandom(32'd1457);
        rst_n = 1'b0; st = 0; dv = 0; ok = 0; dn = 0; inj = 0; mask = '0;
        m = 5'b00001;
        do_reset();

        // R2 R3 directed: both verdict branches and the hold cases.
        step(0, 1, 1, 1, 0, '0, "R2");
        step(1, 0, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 0, 0, '0, "R2");
        step(0, 1, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 0, 0, '0, "R3");
        step(0, 0, 0, 0, 0, '0, "R2");
        step(1, 1, 0, 0, 0, '0, "R2");
        step(0, 1, 1, 0, 0, '0, "R2");
        step(0, 0, 1, 0, 0, '0, "R3");
        step(0, 0, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 1, 0, '0, "R2");

        // R4 R5 R6: every bit flipped in every state.
        for (int s = 0; s < 5; s++) begin
            for (int b = 0; b < 5; b++) begin
                do_reset();
                go_to(s);
                step(0, 0, 0, 0, 1, 5'b00001 << b, "R6");
                step(1, 1, 1, 1, 0, '0, "R4");
                step(0, 0, 0, 0, 0, '0, "R5");
            end
        end

        // R1: reset while the register is corrupted clears everything.
        do_reset();
        go_to(1);
        step(0, 0, 0, 0, 1, 5'b10000, "R6");
        do_reset();

        // R9: odd-weight multi-bit pattern, strict recovers, parity does not flag.
        go_to(1);
        @(negedge clk);
        inj = 1'b1; mask = 5'b00101;
        @(posedge clk); #1;
        check("R6", sa, 5'b00111);
        check("R6", sb, 5'b00111);
        check("R7", {1'b0, fb, wb, rb, cb}, 5'b00000);
        @(negedge clk);
        inj = 1'b0; mask = '0;
        @(posedge clk); #1;
        check("R9", sb, 5'b00001);
        check("R9", {4'b0, ub}, 5'b00001);
        check("R9", {4'b0, ua}, 5'b00000);
        do_reset();

        // Random traffic with occasional single-bit upsets.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic        e;
            r = $urandom;
            e = (r[7:4] == 4'd0) && ($countones(m) == 1);
            step(r[0], r[1], r[2], r[3], e, 5'b00001 << (r[15:8] % 5),
                 (m == 5'b00100) ? "R3" : "R2");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule